// File: doc/BRIEF.md
# Two-Wire Command Slave with Busy Refusal

This block is the serial front end of a register-controlled device. It watches a two-wire bus (a clock line and an open-drain data line) through synchronizers. It finds start and stop conditions and compares the address byte with a 7-bit identity. On a write, it collects data bytes in pairs and presents each pair as one 16-bit command word, with a single-cycle strobe, to the logic behind it. On a read, it returns a 16-bit word from that logic as two bytes, high byte first.

The lowest two address bits come from a strap input with three legal settings, so up to three copies can share one bus. A `busy` input, raised by the device during a long internal operation such as a non-volatile store, makes the slave leave its address unacknowledged. A master can therefore keep addressing the slave until it answers. The system clock must run at least eight times faster than the bus clock.

Top module: `serial_cmd_slave`

## Requirements
- R1: After reset the slave does not pull the data line low and `cmdValid` is 0.
- R2: The slave acknowledges, in the ninth clock of the address byte, an address of 01011 followed by two strap-selected bits: `addrStrap` 2'b00 gives 0101111, 2'b01 gives 0101100, 2'b10 gives 0101110.
- R3: Any other address leaves the ninth clock unacknowledged, and the slave drives nothing until the next start condition. This covers the all-zero general call, a 10-bit prefix 11110xx, and every address when `addrStrap` is 2'b11.
- R4: In a write (R/W bit 0), both data bytes are acknowledged. After the second byte's acknowledge clock ends, `cmdValid` pulses for exactly one cycle with `cmdWord` = {first byte, second byte}.
- R5: After one address byte, further byte pairs may follow. Each pair produces its own command, in order, until a stop condition.
- R6: A stop condition after an odd data byte discards that byte. No command is issued for it.
- R7: In a read (R/W bit 1), the slave sends `rdWord[15:8]` and then `rdWord[7:0]`, MSB first. Each byte is captured when its first bit is put on the line. The second byte is sent only if the master acknowledges the first.
- R8: If the master does not acknowledge the first read byte, the slave releases the data line for the rest of the transfer.
- R9: If `busy` is 1 when the address byte completes, the address is not acknowledged. With `busy` at 0 the address is acknowledged. A change of `busy` after the address has been accepted has no effect on that transfer.
- R10: A start condition seen in the middle of a byte abandons the current frame and begins receiving a new address byte.
- R11: The slave changes its drive of the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | 1 pulls the data line low (open-drain enable) |
| addrStrap | input | 2 | Three-state address strap encoding: 00, 01, 10 legal; 11 disables the slave |
| busy | input | 1 | Internal operation in progress; address refused while 1 |
| rdWord | input | 16 | Word returned on a read |
| cmdValid | output | 1 | One-cycle strobe: new command on `cmdWord` |
| cmdWord | output | 16 | Last completed command, first byte in the upper half |

## Verification
The functions most likely to collide are the busy refusal and command delivery. `busy` can change while a write that has already been accepted is still moving. The bench raises `busy` between the two data bytes of an accepted write and expects that command to come out unchanged. Across separate transactions it also expects that only an address byte completing while `busy` is high goes unacknowledged. A second collision is a start condition arriving partway through a data byte. It is judged by the half-word that was in flight never showing up as a command, while the write that follows is delivered exactly once.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaLevel;
  } busEvt_t;

  typedef struct packed {
    logic shiftIn;
    logic saveHi;
    logic issueCmd;
    logic loadTxHi;
    logic loadTxLo;
    logic shiftTx;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK, ST_IGNORE
  } state_t;

  // {legal, low address bits} for the three-state strap
  function automatic logic [2:0] strapDecode(input logic [1:0] strap);
    case (strap)
      2'b00:   return 3'b111;
      2'b01:   return 3'b100;
      2'b10:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/scs_datapath.sv
module scs_datapath
  import scs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] rdWord,
  output busEvt_t           ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [WORD_W-1:0] cmdWord
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclS, sdaS;
  logic [BYTE_W-1:0] hiByte, txReg;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.sclRise  = sclS & ~sclPrev;
    ev.sclFall  = ~sclS & sclPrev;
    ev.start    = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stop     = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.sdaLevel = sdaS;
  end

  assign txBit = txReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      rxByte  <= '0;
      hiByte  <= '0;
      txReg   <= '1;
      cmdWord <= '0;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (stb.shiftIn)  rxByte  <= {rxByte[BYTE_W-2:0], sdaS};
      if (stb.saveHi)   hiByte  <= rxByte;
      if (stb.issueCmd) cmdWord <= {hiByte, rxByte};
      if (stb.loadTxHi)      txReg <= rdWord[WORD_W-1:BYTE_W];
      else if (stb.loadTxLo) txReg <= rdWord[BYTE_W-1:0];
      else if (stb.shiftTx)  txReg <= {txReg[BYTE_W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/scs_control.sv
module scs_control
  import scs_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic [1:0]        addrStrap,
  input  logic              busy,
  output strobe_t           stb,
  output logic              sdaDriveLow,
  output logic              cmdValid
);
  state_t state;
  logic [3:0] bitCnt;
  logic ackDrive, txActive, lowHalf, isRead, masterAck;
  logic [2:0] strapInfo;
  logic addrHit, byteDone, quiet;

  assign strapInfo = strapDecode(addrStrap);
  assign addrHit   = strapInfo[2] && (rxByte[BYTE_W-1:1] == {ADDR_PREFIX, strapInfo[1:0]});
  assign byteDone  = ev.sclFall && (bitCnt == LAST_BIT);
  assign quiet     = !ev.start && !ev.stop;
  assign sdaDriveLow = ackDrive | (txActive & ~txBit);

  always_comb begin
    stb = '0;
    if (quiet) begin
      case (state)
        ST_ADDR:     stb.shiftIn  = ev.sclRise && (bitCnt != LAST_BIT);
        ST_WR_BYTE: begin
          stb.shiftIn = ev.sclRise && (bitCnt != LAST_BIT);
          stb.saveHi  = byteDone && !lowHalf;
        end
        ST_WR_ACK:   stb.issueCmd = ev.sclFall && lowHalf;
        ST_ADDR_ACK: stb.loadTxHi = ev.sclFall && isRead;
        ST_RD_BYTE:  stb.shiftTx  = ev.sclFall && (bitCnt != LAST_BIT);
        ST_RD_ACK:   stb.loadTxLo = ev.sclFall && masterAck && !lowHalf;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txActive  <= 1'b0;
      lowHalf   <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      cmdValid  <= 1'b0;
    end else begin
      cmdValid <= stb.issueCmd;
      if (ev.start || ev.stop) begin
        state    <= ev.start ? ST_ADDR : ST_IDLE;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txActive <= 1'b0;
        lowHalf  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR_BYTE: begin
            if (ev.sclRise && bitCnt != LAST_BIT) bitCnt <= bitCnt + 4'd1;
            else if (byteDone) begin
              bitCnt <= '0;
              if (state == ST_WR_BYTE) begin
                ackDrive <= 1'b1;
                state    <= ST_WR_ACK;
              end else if (addrHit && !busy) begin
                ackDrive <= 1'b1;
                isRead   <= rxByte[0];
                state    <= ST_ADDR_ACK;
              end else state <= ST_IGNORE;
            end
          end
          ST_ADDR_ACK: if (ev.sclFall) begin
            ackDrive <= 1'b0;
            lowHalf  <= 1'b0;
            txActive <= isRead;
            state    <= isRead ? ST_RD_BYTE : ST_WR_BYTE;
          end
          ST_WR_ACK: if (ev.sclFall) begin
            ackDrive <= 1'b0;
            lowHalf  <= ~lowHalf;
            state    <= ST_WR_BYTE;
          end
          ST_RD_BYTE: begin
            if (ev.sclRise && bitCnt != LAST_BIT) bitCnt <= bitCnt + 4'd1;
            else if (byteDone) begin
              bitCnt   <= '0;
              txActive <= 1'b0;
              state    <= ST_RD_ACK;
            end
          end
          ST_RD_ACK: begin
            if (ev.sclRise) masterAck <= ~ev.sdaLevel;
            else if (ev.sclFall) begin
              if (masterAck && !lowHalf) begin
                txActive <= 1'b1;
                lowHalf  <= 1'b1;
                state    <= ST_RD_BYTE;
              end else state <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic driveEdgeOk;
  assign driveEdgeOk = ev.sclFall | ev.start | ev.stop;

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> $past(driveEdgeOk));

  assert_cmd_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_busy_refuses_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteDone && busy && quiet) |=> (!sdaDriveLow && state == ST_IGNORE));

  assert_read_nack_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_ACK && ev.sclFall && !masterAck && quiet) |=> !sdaDriveLow);

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rstN)
    ev.start |=> (state == ST_ADDR && bitCnt == 4'd0 && !sdaDriveLow));
endmodule

// File: rtl/serial_cmd_slave.sv
module serial_cmd_slave
  import scs_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [1:0]        addrStrap,
  input  logic              busy,
  input  logic [WORD_W-1:0] rdWord,
  output logic              cmdValid,
  output logic [WORD_W-1:0] cmdWord
);
  busEvt_t           ev;
  strobe_t           stb;
  logic [BYTE_W-1:0] rxByte;
  logic              txBit;

  scs_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .rdWord(rdWord), .ev(ev), .rxByte(rxByte), .txBit(txBit), .cmdWord(cmdWord)
  );

  scs_control #(.ADDR_PREFIX(ADDR_PREFIX)) u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .txBit(txBit),
    .addrStrap(addrStrap), .busy(busy), .stb(stb),
    .sdaDriveLow(sdaDriveLow), .cmdValid(cmdValid)
  );
endmodule

// File: tb/serial_cmd_slave_test.sv
module serial_cmd_slave_test;
  localparam int Q = 5;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] addrStrap = 2'b00;
  logic busy = 1'b0;
  logic [15:0] rdWord = 16'hA5C3;
  logic sdaDriveLow, cmdValid;
  logic [15:0] cmdWord;
  wire  sdaLine = sdaM & ~sdaDriveLow;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] expQ[$];
  logic prevDrive = 1'b0;

  always #5 clk = ~clk;

  serial_cmd_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .addrStrap(addrStrap), .busy(busy), .rdWord(rdWord),
    .cmdValid(cmdValid), .cmdWord(cmdWord)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference: commands expected in order, compared every clock
  always @(negedge clk) begin
    if (rstN) begin
      if (cmdValid) begin
        if (expQ.size() == 0) check(1'b0, "R4/R6 unexpected command", cmdWord, 16'h0);
        else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(cmdWord == e, "R4/R5 command word", cmdWord, e);
        end
      end
      if (sdaDriveLow != prevDrive)
        check(sclM == 1'b0, "R11 drive change with clock low", {15'd0, sclM}, 16'd0);
      prevDrive = sdaDriveLow;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clock_bit(input logic drv, output logic seen);
    wait_q(); sdaM = drv;
    wait_q(); sclM = 1'b1;
    wait_q(); seen = sdaLine;
    wait_q(); sclM = 1'b0;
  endtask

  task automatic put_start();
    wait_q(); sdaM = 1'b1;
    wait_q(); sclM = 1'b1;
    wait_q(); sdaM = 1'b0;
    wait_q(); sclM = 1'b0;
  endtask

  task automatic put_stop();
    wait_q(); sdaM = 1'b0;
    wait_q(); sclM = 1'b1;
    wait_q(); sdaM = 1'b1;
    wait_q();
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      v[i] = s;
    end
    clock_bit(~mAck, s);
  endtask

  task automatic expect_ack(input logic [7:0] v, input logic exp, input string tag);
    logic a;
    write_byte(v, a);
    check(a == exp, tag, {15'd0, a}, {15'd0, exp});
  endtask

  task automatic queue_empty(input string tag);
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, tag, 16'(expQ.size()), 16'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic s;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R1 reset drive", {15'd0, sdaDriveLow}, 16'd0);
    check(cmdValid == 1'b0, "R1 reset strobe", {15'd0, cmdValid}, 16'd0);

    // R2 R4 R5: strap 00 -> 0101111, multiple pairs under one address
    addrStrap = 2'b00;
    put_start();
    expect_ack(8'h5E, 1'b1, "R2 strap00 address ack");
    expQ.push_back(16'h1C03);
    expect_ack(8'h1C, 1'b1, "R4 first data ack");
    expect_ack(8'h03, 1'b1, "R4 second data ack");
    expQ.push_back(16'h0500);
    expect_ack(8'h05, 1'b1, "R5 pair two high");
    expect_ack(8'h00, 1'b1, "R5 pair two low");
    expQ.push_back(16'h0C00);
    expect_ack(8'h0C, 1'b1, "R5 pair three high");
    expect_ack(8'h00, 1'b1, "R5 pair three low");
    put_stop();
    queue_empty("R5 all pairs delivered");

    // R2: strap 01 -> 0101100, strap 10 -> 0101110
    addrStrap = 2'b01;
    put_start();
    expect_ack(8'h58, 1'b1, "R2 strap01 address ack");
    expQ.push_back(16'h1234);
    expect_ack(8'h12, 1'b1, "R4 data ack");
    expect_ack(8'h34, 1'b1, "R4 data ack");
    put_stop();
    addrStrap = 2'b10;
    put_start();
    expect_ack(8'h5C, 1'b1, "R2 strap10 address ack");
    put_stop();
    queue_empty("R2 strap01 command");

    // R3: foreign address, general call, 10-bit prefix, disabled strap
    addrStrap = 2'b00;
    put_start();
    expect_ack(8'h58, 1'b0, "R3 other address nack");
    expect_ack(8'hAA, 1'b0, "R3 no drive after nack");
    put_stop();
    put_start();
    expect_ack(8'h00, 1'b0, "R3 general call nack");
    put_stop();
    put_start();
    expect_ack(8'hF0, 1'b0, "R3 ten-bit prefix nack");
    put_stop();
    addrStrap = 2'b11;
    put_start(); expect_ack(8'h5E, 1'b0, "R3 strap11 0101111"); put_stop();
    put_start(); expect_ack(8'h58, 1'b0, "R3 strap11 0101100"); put_stop();
    put_start(); expect_ack(8'h5C, 1'b0, "R3 strap11 0101110"); put_stop();
    queue_empty("R3 no command");

    // R6: odd byte then stop is discarded
    addrStrap = 2'b00;
    put_start();
    expect_ack(8'h5E, 1'b1, "R6 address ack");
    expect_ack(8'h77, 1'b1, "R6 lone byte ack");
    put_stop();
    queue_empty("R6 lone byte discarded");
    put_start();
    expect_ack(8'h5E, 1'b1, "R6 next address ack");
    expQ.push_back(16'h0102);
    expect_ack(8'h01, 1'b1, "R6 fresh pair high");
    expect_ack(8'h02, 1'b1, "R6 fresh pair low");
    put_stop();
    queue_empty("R6 fresh pair only");

    // R7: two-byte read, master acks first byte
    put_start();
    expect_ack(8'h5F, 1'b1, "R7 read address ack");
    read_byte(1'b1, rb);
    check(rb == 8'hA5, "R7 read high byte", {8'd0, rb}, 16'h00A5);
    read_byte(1'b0, rb);
    check(rb == 8'hC3, "R7 read low byte", {8'd0, rb}, 16'h00C3);
    put_stop();

    // R8: master declines first byte, second byte not driven
    put_start();
    expect_ack(8'h5F, 1'b1, "R8 read address ack");
    read_byte(1'b0, rb);
    check(rb == 8'hA5, "R8 first byte", {8'd0, rb}, 16'h00A5);
    read_byte(1'b0, rb);
    check(rb == 8'hFF, "R8 second byte released", {8'd0, rb}, 16'h00FF);
    put_stop();

    // R9: busy refusal, polling, busy change mid transfer
    busy = 1'b1;
    put_start();
    expect_ack(8'h5E, 1'b0, "R9 busy nack");
    put_stop();
    busy = 1'b0;
    put_start();
    expect_ack(8'h5E, 1'b1, "R9 ack after busy");
    expQ.push_back(16'hABCD);
    expect_ack(8'hAB, 1'b1, "R9 high byte");
    busy = 1'b1;
    expect_ack(8'hCD, 1'b1, "R9 low byte under busy");
    put_stop();
    busy = 1'b0;
    queue_empty("R9 in-flight write kept");

    // R10: start inside an address byte and inside a data byte
    put_start();
    for (int i = 0; i < 4; i++) clock_bit(i[0], s);
    put_start();
    expect_ack(8'h5E, 1'b1, "R10 address after restart");
    expect_ack(8'h66, 1'b1, "R10 data byte");
    for (int i = 0; i < 3; i++) clock_bit(1'b0, s);
    put_start();
    expect_ack(8'h5E, 1'b1, "R10 second restart address");
    expQ.push_back(16'h7071);
    expect_ack(8'h70, 1'b1, "R10 pair high");
    expect_ack(8'h71, 1'b1, "R10 pair low");
    put_stop();
    queue_empty("R10 only completed pair delivered");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule